// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block turns one routed interrupt request into injection strobes towards a small set of processors. It holds a table with one entry per processor slot: a presence bit, a physical ID and a logical ID. A request carries a destination ID, a flag selecting physical or logical addressing, a delivery mode, a vector and a trigger-level bit. From these fields the block works out a mask of target processors and then delivers the interrupt.

In physical addressing the all-ones destination reaches every present processor. Any other destination reaches only the lowest-indexed present processor whose physical ID is equal to it. In logical addressing a zero destination reaches nothing. A nonzero destination reaches every present processor whose logical ID has at least one bit in common with it. Fixed delivery serves the targets one per cycle, from the lowest index upwards. Lowest-priority delivery picks one target by rotating through the mask. Any other delivery mode is reported as unsupported and dropped.

A new request is taken only while the block is idle, which it signals on `req_ready`. Each request ends with exactly one completion pulse (`disp_done`) or one drop pulse (`disp_dropped`).

Top module: `irq_dest_dispatch`

## Requirements
- R1: After reset `req_ready` is 1, `inj_strobe` is all zero, `disp_done`, `disp_dropped` and `disp_unsupported` are 0, and the first lowest-priority pick starts its search at slot 0.
- R2: In physical mode (`req_logical`=0), a destination of all ones (8'hFF) targets every slot whose presence bit is set.
- R3: In physical mode, any other destination targets only the lowest-indexed present slot whose physical ID equals the destination. A later slot with the same ID is not targeted.
- R4: In logical mode (`req_logical`=1), a destination of zero targets no slot, so the request is dropped.
- R5: In logical mode with a nonzero destination, every present slot whose logical ID ANDed with the destination is nonzero is targeted.
- R6: A request whose target mask is empty produces no strobe. `disp_dropped` pulses for one cycle, one cycle after acceptance.
- R7: Fixed delivery (`req_dmode`=3'd0) raises one one-hot strobe per cycle, in ascending slot order. The first strobe comes in the cycle after acceptance and `disp_done` is high together with the last strobe.
- R8: Lowest-priority delivery (`req_dmode`=3'd1) raises exactly one strobe, together with `disp_done`, in the cycle after acceptance. The target is the first mask bit found cyclically after the previous winner. A dropped request does not move that position.
- R9: Every other `req_dmode` code (3'd2 to 3'd7, NMI included) produces no strobe and pulses `disp_dropped` and `disp_unsupported` together.
- R10: `req_ready` is 0 while fixed delivery still has targets to serve, and a request presented during that time is ignored.
- R11: `inj_vector` and `inj_level` carry the vector and level of the accepted request with every strobe.
- R12: A table write (`tbl_wr_en`) updates the addressed slot at the clock edge, and later requests use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_wr_en | input | 1 | Write one table slot |
| tbl_wr_sel | input | 3 | Slot index to write |
| tbl_wr_present | input | 1 | Presence bit to store |
| tbl_wr_phys_id | input | 8 | Physical ID to store |
| tbl_wr_logic_id | input | 8 | Logical ID to store |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dest | input | 8 | Destination ID |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_dmode | input | 3 | Delivery mode: 0 fixed, 1 lowest priority, others unsupported |
| req_vector | input | 8 | Interrupt vector |
| req_level | input | 1 | Trigger mode (1 level) |
| inj_strobe | output | 8 | One-hot injection strobe per slot |
| inj_vector | output | 8 | Vector sent with the strobe |
| inj_level | output | 1 | Trigger mode sent with the strobe |
| disp_done | output | 1 | Last injection of the request |
| disp_dropped | output | 1 | Request ended with no injection |
| disp_unsupported | output | 1 | Drop caused by an unsupported delivery mode |

## Verification
The hardest state to reach is the rotating lowest-priority position, because it cannot be seen from the ports and depends on every earlier winner. The stimulus table therefore runs a fixed chain of lowest-priority requests over different masks, with a dropped request in the middle, so that each expected winner follows from the previous one. A second hard case is a request that arrives while fixed delivery is still working through its targets. A directed test presents such a request in the middle of a seven-target broadcast and then checks that only the broadcast's strobes appear.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   typedef enum logic [2:0] {
      DM_FIXED   = 3'd0,
      DM_LOWEST  = 3'd1,
      DM_SMI     = 3'd2,
      DM_RSVD3   = 3'd3,
      DM_NMI     = 3'd4,
      DM_INIT    = 3'd5,
      DM_RSVD6   = 3'd6,
      DM_EXTINT  = 3'd7
   } dmode_e;

   function automatic logic mode_supported(input logic [2:0] m);
      return (m == DM_FIXED) || (m == DM_LOWEST);
   endfunction
endpackage

// File: rtl/irqd_target_table.sv
module irqd_target_table #(
   parameter int N     = 8,
   parameter int ID_W  = 8,
   localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_sel,
   input  logic                     wr_present,
   input  logic [ID_W-1:0]          wr_phys,
   input  logic [ID_W-1:0]          wr_logic,
   output logic [N-1:0]             present,
   output logic [N-1:0][ID_W-1:0]   phys_id,
   output logic [N-1:0][ID_W-1:0]   logic_id
);
   for (genvar i = 0; i < N; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            present[i]  <= 1'b0;
            phys_id[i]  <= '0;
            logic_id[i] <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(i))) begin
            present[i]  <= wr_present;
            phys_id[i]  <= wr_phys;
            logic_id[i] <= wr_logic;
         end
      end
   end
endmodule

// File: rtl/irqd_target_match.sv
module irqd_target_match #(
   parameter int N    = 8,
   parameter int ID_W = 8
) (
   input  logic [ID_W-1:0]          dest,
   input  logic                     logical,
   input  logic [N-1:0]             present,
   input  logic [N-1:0][ID_W-1:0]   phys_id,
   input  logic [N-1:0][ID_W-1:0]   logic_id,
   output logic [N-1:0]             mask
);
   localparam logic [ID_W-1:0] BCAST = '1;

   logic [N-1:0] phys_hit;
   logic [N-1:0] logic_hit;
   logic [N-1:0] phys_first;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign phys_hit[i]  = present[i] && (phys_id[i] == dest);
      assign logic_hit[i] = present[i] && (|(logic_id[i] & dest));
   end

   // keep only the lowest-index physical match
   assign phys_first = phys_hit & (~phys_hit + N'(1));

   always_comb begin
      if (!logical) begin
         mask = (dest == BCAST) ? present : phys_first;
      end else if (dest == '0) begin
         mask = '0;
      end else begin
         mask = logic_hit;
      end
   end
endmodule

// File: rtl/irqd_rr_pick.sv
module irqd_rr_pick #(
   parameter int N = 8,
   localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     mask,
   input  logic [SEL_W-1:0] last,
   output logic [N-1:0]     win,
   output logic [SEL_W-1:0] win_idx
);
   always_comb begin
      logic found;
      found   = 1'b0;
      win     = '0;
      win_idx = last;
      for (int off = 1; off <= N; off++) begin
         if (!found && mask[(int'(last) + off) % N]) begin
            found = 1'b1;
            win[(int'(last) + off) % N] = 1'b1;
            win_idx = SEL_W'((int'(last) + off) % N);
         end
      end
   end
endmodule

// File: rtl/irq_dest_dispatch.sv
module irq_dest_dispatch #(
   parameter int N     = 8,
   parameter int ID_W  = 8,
   parameter int VEC_W = 8,
   localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_wr_en,
   input  logic [SEL_W-1:0]  tbl_wr_sel,
   input  logic              tbl_wr_present,
   input  logic [ID_W-1:0]   tbl_wr_phys_id,
   input  logic [ID_W-1:0]   tbl_wr_logic_id,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ID_W-1:0]   req_dest,
   input  logic              req_logical,
   input  logic [2:0]        req_dmode,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic              req_level,
   output logic [N-1:0]      inj_strobe,
   output logic [VEC_W-1:0]  inj_vector,
   output logic              inj_level,
   output logic              disp_done,
   output logic              disp_dropped,
   output logic              disp_unsupported
);
   import irqd_pkg::*;

   // parameter sanity
   initial begin
      if (N < 2 || N > 32) $error("irq_dest_dispatch: N must be 2..32");
      if (ID_W < 1)        $error("irq_dest_dispatch: ID_W must be positive");
      if (VEC_W < 1)       $error("irq_dest_dispatch: VEC_W must be positive");
   end

   logic [N-1:0]             present;
   logic [N-1:0][ID_W-1:0]   phys_id;
   logic [N-1:0][ID_W-1:0]   logic_id;
   logic [N-1:0]             match_mask;
   logic [N-1:0]             rr_win;
   logic [SEL_W-1:0]         rr_win_idx;
   logic [SEL_W-1:0]         rr_last_q;
   logic [N-1:0]             pend_q;

   logic                     accept;
   logic [N-1:0]             serve_src;
   logic [N-1:0]             serve_low;
   logic [N-1:0]             serve_rest;

   irqd_target_table #(.N(N), .ID_W(ID_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (tbl_wr_en),
      .wr_sel     (tbl_wr_sel),
      .wr_present (tbl_wr_present),
      .wr_phys    (tbl_wr_phys_id),
      .wr_logic   (tbl_wr_logic_id),
      .present    (present),
      .phys_id    (phys_id),
      .logic_id   (logic_id)
   );

   irqd_target_match #(.N(N), .ID_W(ID_W)) u_match (
      .dest     (req_dest),
      .logical  (req_logical),
      .present  (present),
      .phys_id  (phys_id),
      .logic_id (logic_id),
      .mask     (match_mask)
   );

   irqd_rr_pick #(.N(N)) u_pick (
      .mask    (match_mask),
      .last    (rr_last_q),
      .win     (rr_win),
      .win_idx (rr_win_idx)
   );

   assign req_ready = (pend_q == '0);
   assign accept    = req_valid && req_ready;

   // one shared lowest-bit server for the first and the following targets
   always_comb begin
      serve_src  = accept ? match_mask : pend_q;
      serve_low  = serve_src & (~serve_src + N'(1));
      serve_rest = serve_src & ~serve_low;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q           <= '0;
         rr_last_q        <= SEL_W'(N - 1);
         inj_strobe       <= '0;
         inj_vector       <= '0;
         inj_level        <= 1'b0;
         disp_done        <= 1'b0;
         disp_dropped     <= 1'b0;
         disp_unsupported <= 1'b0;
      end else begin
         inj_strobe       <= '0;
         disp_done        <= 1'b0;
         disp_dropped     <= 1'b0;
         disp_unsupported <= 1'b0;
         if (accept) begin
            inj_vector <= req_vector;
            inj_level  <= req_level;
            if (!mode_supported(req_dmode)) begin
               disp_dropped     <= 1'b1;
               disp_unsupported <= 1'b1;
            end else if (match_mask == '0) begin
               disp_dropped <= 1'b1;
            end else if (req_dmode == DM_LOWEST) begin
               inj_strobe <= rr_win;
               disp_done  <= 1'b1;
               rr_last_q  <= rr_win_idx;
            end else begin
               inj_strobe <= serve_low;
               pend_q     <= serve_rest;
               disp_done  <= (serve_rest == '0);
            end
         end else if (pend_q != '0) begin
            inj_strobe <= serve_low;
            pend_q     <= serve_rest;
            disp_done  <= (serve_rest == '0);
         end
      end
   end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_ready,
   input logic [N-1:0] inj_strobe,
   input logic         disp_done,
   input logic         disp_dropped,
   input logic         disp_unsupported
);
   a_r7_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inj_strobe));

   a_r6_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      disp_dropped |-> (inj_strobe == '0) && !disp_done);

   a_r9_unsup_drops: assert property (@(posedge clk) disable iff (!rst_n)
      disp_unsupported |-> disp_dropped);

   a_r8_done_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      disp_done |-> ($countones(inj_strobe) == 1));

   a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      ((|inj_strobe) && !disp_done) |=> ((|inj_strobe) && (inj_strobe > $past(inj_strobe))));

   a_r10_busy_while_serving: assert property (@(posedge clk) disable iff (!rst_n)
      ((|inj_strobe) && !disp_done) |-> !req_ready);
endmodule

bind irq_dest_dispatch irqd_checker #(.N(N)) u_irqd_checker (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_ready        (req_ready),
   .inj_strobe       (inj_strobe),
   .disp_done        (disp_done),
   .disp_dropped     (disp_dropped),
   .disp_unsupported (disp_unsupported)
);

// File: tb/tb_irq_dest_dispatch.sv
`timescale 1ns/1ps
module tb_irq_dest_dispatch;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tbl_wr_en = 1'b0;
   logic [2:0] tbl_wr_sel = '0;
   logic       tbl_wr_present = 1'b0;
   logic [7:0] tbl_wr_phys_id = '0;
   logic [7:0] tbl_wr_logic_id = '0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_dest = '0;
   logic       req_logical = 1'b0;
   logic [2:0] req_dmode = '0;
   logic [7:0] req_vector = '0;
   logic       req_level = 1'b0;
   logic [7:0] inj_strobe;
   logic [7:0] inj_vector;
   logic       inj_level;
   logic       disp_done;
   logic       disp_dropped;
   logic       disp_unsupported;

   always #4 clk = ~clk;

   irq_dest_dispatch dut (.*);

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // collected results of one request
   logic [7:0] seen_mask;
   int         seen_cnt;
   bit         order_ok;
   bit         first_ok;
   bit         done_ok;
   bit         drop_seen;
   bit         unsup_seen;
   bit         vec_ok;
   bit         busy_seen;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr_tbl(input int idx, input bit pres, input logic [7:0] ph,
                         input logic [7:0] lg);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_sel = 3'(idx); tbl_wr_present = pres;
      tbl_wr_phys_id = ph; tbl_wr_logic_id = lg;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   task automatic run_req(input logic [7:0] dest, input bit lgc, input logic [2:0] dm,
                          input logic [7:0] vec, input bit lvl, input bit stray);
      int last_strobe;
      int done_at;
      logic [7:0] prev;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_dest = dest; req_logical = lgc; req_dmode = dm;
      req_vector = vec; req_level = lvl;
      @(negedge clk);
      req_valid = 1'b0;
      seen_mask = '0; seen_cnt = 0; order_ok = 1'b1; first_ok = 1'b1;
      drop_seen = 1'b0; unsup_seen = 1'b0; vec_ok = 1'b1; busy_seen = 1'b0;
      last_strobe = -1; done_at = -1; prev = '0;
      for (int k = 0; k < N + 4; k++) begin
         if (stray && k == 0) begin
            busy_seen = !req_ready;
            req_valid = 1'b1; req_dest = 8'h05; req_logical = 1'b1;
            req_dmode = 3'd1; req_vector = 8'h99; req_level = ~lvl;
         end
         if (stray && k == 1) req_valid = 1'b0;
         if (inj_strobe != '0) begin
            if (seen_cnt > 0 && inj_strobe <= prev) order_ok = 1'b0;
            if (seen_cnt == 0 && k != 0) first_ok = 1'b0;
            if (inj_vector != vec || inj_level != lvl) vec_ok = 1'b0;
            prev = inj_strobe;
            seen_mask = seen_mask | inj_strobe;
            seen_cnt += $countones(inj_strobe);
            last_strobe = k;
         end
         if (disp_done) done_at = k;
         if (disp_dropped) drop_seen = 1'b1;
         if (disp_unsupported) unsup_seen = 1'b1;
         @(negedge clk);
      end
      done_ok = (seen_cnt == 0) ? (done_at == -1) : (done_at == last_strobe);
   endtask

   // stimulus table: dest, logical, dmode, expected mask, expected drop, expected unsupported
   localparam int NV = 18;
   localparam logic [21:0] VEC [NV] = '{
      {8'hFF, 1'b0, 3'd0, 8'h7F, 1'b0, 1'b0},
      {8'h03, 1'b0, 3'd0, 8'h08, 1'b0, 1'b0},
      {8'h05, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
      {8'h07, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
      {8'h00, 1'b1, 3'd0, 8'h00, 1'b1, 1'b0},
      {8'h05, 1'b1, 3'd0, 8'h05, 1'b0, 1'b0},
      {8'hF0, 1'b1, 3'd0, 8'h70, 1'b0, 1'b0},
      {8'h80, 1'b1, 3'd0, 8'h00, 1'b1, 1'b0},
      {8'hFF, 1'b0, 3'd4, 8'h00, 1'b1, 1'b1},
      {8'hFF, 1'b0, 3'd2, 8'h00, 1'b1, 1'b1},
      {8'h03, 1'b0, 3'd7, 8'h00, 1'b1, 1'b1},
      {8'hFF, 1'b0, 3'd1, 8'h01, 1'b0, 1'b0},
      {8'hFF, 1'b0, 3'd1, 8'h02, 1'b0, 1'b0},
      {8'hF0, 1'b1, 3'd1, 8'h10, 1'b0, 1'b0},
      {8'h05, 1'b1, 3'd1, 8'h01, 1'b0, 1'b0},
      {8'h00, 1'b1, 3'd1, 8'h00, 1'b1, 1'b0},
      {8'hFF, 1'b0, 3'd1, 8'h02, 1'b0, 1'b0},
      {8'h03, 1'b0, 3'd1, 8'h08, 1'b0, 1'b0}
   };

   function automatic string tag_of(input logic [21:0] v);
      if (v[0])                      return "R9";
      if (v[13] && v[21:14] == 8'h0) return "R4";
      if (v[1])                      return "R6";
      if (v[12:10] == 3'd1)          return "R8";
      if (v[13])                     return "R5";
      if (v[21:14] == 8'hFF)         return "R2";
      return "R3";
   endfunction

   initial begin
      int cyc = 0;
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      check(inj_strobe == '0 && !disp_done && !disp_dropped && !disp_unsupported,
            "R1", "quiet outputs after reset",
            {inj_strobe, disp_done, disp_dropped, disp_unsupported}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && inj_strobe == '0, "R1", "idle after release",
            {req_ready, inj_strobe}, 9'h100);

      // slots 0..6 present, slot 7 absent; slot 5 duplicates physical ID 3
      for (int i = 0; i < N; i++)
         wr_tbl(i, i != 7, (i == 5) ? 8'h03 : 8'(i), 8'(1 << i));

      for (int t = 0; t < NV; t++) begin
         logic [21:0] v;
         v = VEC[t];
         run_req(v[21:14], v[13], v[12:10], 8'(8'h40 + t), t[0], 1'b0);
         check(seen_mask == v[9:2] && seen_cnt == $countones(v[9:2]),
               tag_of(v), $sformatf("targets of vector %0d", t), seen_mask, v[9:2]);
         check(drop_seen == v[1] && unsup_seen == v[0], tag_of(v),
               $sformatf("drop/unsupported of vector %0d", t),
               {drop_seen, unsup_seen}, v[1:0]);
         if (!v[1]) begin
            check(order_ok && first_ok && done_ok, "R7",
                  $sformatf("order/first/done timing of vector %0d", t),
                  {order_ok, first_ok, done_ok}, 3'b111);
            check(vec_ok, "R11", $sformatf("vector/level of vector %0d", t), vec_ok, 1);
         end
      end

      // R10: request during fixed broadcast is ignored
      run_req(8'hFF, 1'b0, 3'd0, 8'h21, 1'b1, 1'b1);
      check(busy_seen, "R10", "ready low while serving", busy_seen, 1);
      check(seen_mask == 8'h7F && seen_cnt == 7 && !drop_seen, "R10",
            "only broadcast strobes after stray request", seen_mask, 8'h7F);
      check(vec_ok, "R11", "vector/level kept during stray request", vec_ok, 1);
      // the stray lowest-priority request was not taken: next pick follows slot 3
      run_req(8'hFF, 1'b0, 3'd1, 8'h22, 1'b0, 1'b0);
      check(seen_mask == 8'h10, "R10", "rotation unaffected by ignored request",
            seen_mask, 8'h10);

      // R12: table rewrite takes effect
      wr_tbl(6, 1'b1, 8'h22, 8'h40);
      run_req(8'h22, 1'b0, 3'd0, 8'h33, 1'b1, 1'b0);
      check(seen_mask == 8'h40 && done_ok, "R12", "new physical ID reached",
            seen_mask, 8'h40);
      wr_tbl(3, 1'b0, 8'h03, 8'h08);
      run_req(8'h03, 1'b0, 3'd0, 8'h34, 1'b0, 1'b0);
      check(seen_mask == 8'h20, "R3", "duplicate ID reached once lower slot absent",
            seen_mask, 8'h20);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule